// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt

This block adds a doorbell between the two ports of an 8K x 16 dual-port memory. It watches the address, chip enable, output enable and read/write strobe of each port. From these it keeps one interrupt flag per port and drives it out as an active-low line. The two highest words of the memory are the message slots. Each port writes a message into its partner's slot, and that write raises the partner's interrupt. The partner reads the slot, and that read drops the interrupt. The words themselves are ordinary storage: this block holds no data. It only watches the accesses.

All port inputs are sampled on the rising clock edge. A flag changes at the edge that samples the access that changes it, and the interrupt output follows that flag with no further register. There is no data stream at this block's edge, so every pin is a plain level control or status signal with no valid/ready handshake. Driving the enable input low turns the feature off: both lines go inactive, and the two top words act as plain memory.

Top module: `mbx_irq`

## Requirements
- R1: After reset, `irq_l_n` and `irq_r_n` are both high (inactive).
- R2: With `mbx_en` high, a right-port write (`r_ce_n`=0, `r_rw_n`=0) to address 0x1FFE (all-ones minus one) makes `irq_l_n` low after the sampling edge.
- R3: With `mbx_en` high, a left-port write (`l_ce_n`=0, `l_rw_n`=0) to address 0x1FFF (all ones) makes `irq_r_n` low after the sampling edge.
- R4: A left-port access to 0x1FFE with `l_ce_n`=0 and `l_oe_n`=0 returns `irq_l_n` high, whatever the level of `l_rw_n`.
- R5: A right-port access to 0x1FFF with `r_ce_n`=0 and `r_oe_n`=0 returns `irq_r_n` high, whatever the level of `r_rw_n`.
- R6: A write sets a flag only when both chip enable and the strobe are low and the address is the exact slot. A write to any other address, or with either of those signals high, leaves the line unchanged.
- R7: The clearing access needs both chip enable and output enable low. An access to the own slot with either of them high leaves the line low.
- R8: If a set and a clear of the same flag are sampled at the same edge, the set wins and the line stays low.
- R9: While `mbx_en` is low, both lines are high one edge later and writes to the slots set nothing.
- R10: With no set or clear, a flag holds its value. A port that reads its partner's slot, or writes its own slot, leaves its own flag as it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mbx_en | input | 1 | Mailbox interrupt feature enable |
| l_addr | input | 13 | Left-port address |
| l_ce_n | input | 1 | Left-port chip enable, active low |
| l_oe_n | input | 1 | Left-port output enable, active low |
| l_rw_n | input | 1 | Left-port read/write strobe, low = write |
| r_addr | input | 13 | Right-port address |
| r_ce_n | input | 1 | Right-port chip enable, active low |
| r_oe_n | input | 1 | Right-port output enable, active low |
| r_rw_n | input | 1 | Right-port read/write strobe, low = write |
| irq_l_n | output | 1 | Left-port interrupt, active low |
| irq_r_n | output | 1 | Right-port interrupt, active low |

## Verification
Setting a flag and clearing it can land on the same edge. This happens when one port posts a message while the other port is reading its slot. The bench provokes this by driving a right-port write and a left-port read of 0x1FFE in the same cycle. It expects `irq_l_n` to stay low, and to rise only after a later read on its own. The same collision is also watched by a property on the flag register.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned NUM_PORTS = 2;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  function automatic int unsigned other_side(input int unsigned s);
    return (s == 0) ? 1 : 0;
  endfunction
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] OWN_SLOT  = '0,
  parameter logic [ADDR_W-1:0] PEER_SLOT = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              rw_n,
  input  logic              en,
  output logic              post_peer,
  output logic              take_own
);
  logic selected;
  logic is_write;
  logic is_read_access;

  assign selected       = en & ~ce_n;
  assign is_write       = selected & ~rw_n;
  // strobe level is a don't-care for the clearing access
  assign is_read_access = selected & ~oe_n;

  assign post_peer = is_write & (addr == PEER_SLOT);
  assign take_own  = is_read_access & (addr == OWN_SLOT);
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    if (!en)      flag_d = 1'b0;
    else if (set) flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set && clr) |=> flag_q);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !set && !clr) |=> $stable(flag_q));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mbx_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_ce_n,
  input  logic              l_oe_n,
  input  logic              l_rw_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_ce_n,
  input  logic              r_oe_n,
  input  logic              r_rw_n,
  output logic              irq_l_n,
  output logic              irq_r_n
);
  import mbx_pkg::*;

  localparam logic [ADDR_W-1:0] SLOT_R = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] SLOT_L = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic [ADDR_W-1:0] addr_a [NUM_PORTS];
  logic              ce_a   [NUM_PORTS];
  logic              oe_a   [NUM_PORTS];
  logic              rw_a   [NUM_PORTS];
  logic              post_a [NUM_PORTS];
  logic              take_a [NUM_PORTS];
  logic              flag_a [NUM_PORTS];

  assign addr_a[SIDE_LEFT]  = l_addr;
  assign ce_a[SIDE_LEFT]    = l_ce_n;
  assign oe_a[SIDE_LEFT]    = l_oe_n;
  assign rw_a[SIDE_LEFT]    = l_rw_n;
  assign addr_a[SIDE_RIGHT] = r_addr;
  assign ce_a[SIDE_RIGHT]   = r_ce_n;
  assign oe_a[SIDE_RIGHT]   = r_oe_n;
  assign rw_a[SIDE_RIGHT]   = r_rw_n;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int unsigned PEER = other_side(p);
    localparam logic [ADDR_W-1:0] OWN = (p == 0) ? SLOT_L : SLOT_R;
    localparam logic [ADDR_W-1:0] OPP = (p == 0) ? SLOT_R : SLOT_L;

    mbx_port_decode #(
      .ADDR_W   (ADDR_W),
      .OWN_SLOT (OWN),
      .PEER_SLOT(OPP)
    ) u_dec (
      .addr     (addr_a[p]),
      .ce_n     (ce_a[p]),
      .oe_n     (oe_a[p]),
      .rw_n     (rw_a[p]),
      .en       (mbx_en),
      .post_peer(post_a[p]),
      .take_own (take_a[p])
    );

    mbx_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (mbx_en),
      .set   (post_a[PEER]),
      .clr   (take_a[p]),
      .flag_q(flag_a[p])
    );
  end

  assign irq_l_n = ~flag_a[SIDE_LEFT];
  assign irq_r_n = ~flag_a[SIDE_RIGHT];

  logic r_posts_l, l_posts_r;
  assign r_posts_l = mbx_en && !r_ce_n && !r_rw_n && (r_addr == SLOT_L);
  assign l_posts_r = mbx_en && !l_ce_n && !l_rw_n && (l_addr == SLOT_R);

  p_left_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    r_posts_l |=> !irq_l_n);

  p_right_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    l_posts_r |=> !irq_r_n);

  p_left_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_en && !l_ce_n && !l_oe_n && l_addr == SLOT_L && !r_posts_l) |=> irq_l_n);

  p_right_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_en && !r_ce_n && !r_oe_n && r_addr == SLOT_R && !l_posts_r) |=> irq_r_n);

  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mbx_en |=> (irq_l_n && irq_r_n));
endmodule

// File: tb/mbx_irq_bench.sv
module mbx_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam logic [AW-1:0] A_L = 13'h1FFE;
  localparam logic [AW-1:0] A_R = 13'h1FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mbx_en = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_ce_n = 1'b1, l_oe_n = 1'b1, l_rw_n = 1'b1;
  logic r_ce_n = 1'b1, r_oe_n = 1'b1, r_rw_n = 1'b1;
  logic irq_l_n, irq_r_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_irq #(.ADDR_W(AW)) u_mbx_irq (
    .clk(clk), .rst_n(rst_n), .mbx_en(mbx_en),
    .l_addr(l_addr), .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_rw_n(l_rw_n),
    .r_addr(r_addr), .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_rw_n(r_rw_n),
    .irq_l_n(irq_l_n), .irq_r_n(irq_r_n)
  );

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic idle();
    l_ce_n = 1'b1; l_oe_n = 1'b1; l_rw_n = 1'b1; l_addr = '0;
    r_ce_n = 1'b1; r_oe_n = 1'b1; r_rw_n = 1'b1; r_addr = '0;
  endtask

  // inputs change at negedge; the next posedge samples; check at the following negedge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic l_acc(input logic [AW-1:0] a, input logic ce, input logic oe, input logic rw);
    l_addr = a; l_ce_n = ce; l_oe_n = oe; l_rw_n = rw;
  endtask

  task automatic r_acc(input logic [AW-1:0] a, input logic ce, input logic oe, input logic rw);
    r_addr = a; r_ce_n = ce; r_oe_n = oe; r_rw_n = rw;
  endtask

  task automatic t_reset();
    check(irq_l_n, 1'b1, "R1 left line after reset");
    check(irq_r_n, 1'b1, "R1 right line after reset");
  endtask

  task automatic t_left_doorbell();
    r_acc(A_L, 1'b0, 1'b1, 1'b0); step();
    check(irq_l_n, 1'b0, "R2 right write to 0x1FFE");
    check(irq_r_n, 1'b1, "R2 right line untouched");
    step(); step();
    check(irq_l_n, 1'b0, "R10 hold while idle");
    l_acc(A_R, 1'b0, 1'b0, 1'b1); step();
    check(irq_l_n, 1'b0, "R10 left read of peer slot keeps flag");
    l_acc(A_L, 1'b0, 1'b1, 1'b1); step();
    check(irq_l_n, 1'b0, "R7 oe high does not clear");
    l_acc(A_L, 1'b1, 1'b0, 1'b1); step();
    check(irq_l_n, 1'b0, "R7 ce high does not clear");
    l_acc(A_L, 1'b0, 1'b0, 1'b0); step();
    check(irq_l_n, 1'b1, "R4 clear with strobe low");
    check(irq_r_n, 1'b1, "R10 left write to own slot sets nothing");
  endtask

  task automatic t_right_doorbell();
    l_acc(A_R, 1'b0, 1'b1, 1'b0); step();
    check(irq_r_n, 1'b0, "R3 left write to 0x1FFF");
    check(irq_l_n, 1'b1, "R3 left line untouched");
    r_acc(A_R, 1'b0, 1'b0, 1'b1); step();
    check(irq_r_n, 1'b1, "R5 right read clears");
  endtask

  task automatic t_write_qual();
    r_acc(A_L, 1'b1, 1'b1, 1'b0); step();
    check(irq_l_n, 1'b1, "R6 ce high write ignored");
    r_acc(A_L, 1'b0, 1'b1, 1'b1); step();
    check(irq_l_n, 1'b1, "R6 read is not a write");
    r_acc(13'h1FFD, 1'b0, 1'b1, 1'b0); step();
    check(irq_l_n, 1'b1, "R6 other address ignored");
    l_acc(A_L, 1'b0, 1'b1, 1'b0); step();
    check(irq_r_n, 1'b1, "R6 left write to wrong slot");
  endtask

  task automatic t_collide();
    r_acc(A_L, 1'b0, 1'b1, 1'b0);
    l_acc(A_L, 1'b0, 1'b0, 1'b1); step();
    check(irq_l_n, 1'b0, "R8 set beats same-cycle clear");
    l_acc(A_L, 1'b0, 1'b0, 1'b1); step();
    check(irq_l_n, 1'b1, "R4 later clear alone");
  endtask

  task automatic t_disable();
    r_acc(A_L, 1'b0, 1'b1, 1'b0);
    l_acc(A_R, 1'b0, 1'b1, 1'b0); step();
    check(irq_l_n, 1'b0, "R2 setup left");
    check(irq_r_n, 1'b0, "R3 setup right");
    mbx_en = 1'b0; step();
    check(irq_l_n, 1'b1, "R9 disable drops left");
    check(irq_r_n, 1'b1, "R9 disable drops right");
    r_acc(A_L, 1'b0, 1'b1, 1'b0);
    l_acc(A_R, 1'b0, 1'b1, 1'b0); step();
    check(irq_l_n, 1'b1, "R9 write while off ignored left");
    check(irq_r_n, 1'b1, "R9 write while off ignored right");
    mbx_en = 1'b1; step();
    check(irq_l_n, 1'b1, "R9 re-enable leaves left idle");
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_left_doorbell();
    t_right_doorbell();
    t_write_qual();
    t_collide();
    t_disable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule